// File: doc/BRIEF.md
# Serial Crosspoint Configuration Controller

This block is the digital control plane of a 16-input, 16-output routing switch. A host sends 16-bit command words over a three-wire serial link. The link has an active-low frame enable, a serial clock and serial data. The block decodes each complete word and updates a register file. For every output, that file holds a 4-bit source select, an enable bit and a gain bit. A common enable, a power-on flag and a broadcast setting are shared by all outputs. From this state the block drives, for every output, the effective source index, a drive enable and a gain select.

The serial pins are sampled in the block's own clock domain. Each pin passes through a short synchroniser, and edges are found on the synchronised level, so the serial clock must be several times slower than the system clock. A word acts only when the frame enable returns high, and only if exactly 16 bits were shifted in during the frame. Broadcast mode forces every output onto one input. The stored per-output routing is kept, so it returns when broadcast is cleared. The serial output presents the bits pushed out of the shift register, which allows readback or daisy-chaining.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: After reset, every drive enable and gain select is 0, every source index is 0, broadcast, power-on and common enable are off, and the serial output is 0.
- R2: Bits are captured on rising serial-clock edges while the frame enable is low, the first bit being word bit 15. The word acts only after the frame enable rises, and only if exactly 16 rising edges occurred in the frame; any other count leaves all state unchanged.
- R3: Serial-clock edges while the frame enable is high change neither the register file nor the shift register.
- R4: Opcode (bits 15:13) 000 routes an output: source index from bits 12:9 to the output numbered by bits 4:1. If bit 8 or bit 0 is 1, the word is discarded.
- R5: Opcode 001 writes four output enables: group N is taken from bits 9:8, and bits 0, 2, 4, 6 set outputs 4N, 4N+1, 4N+2, 4N+3. Other outputs keep their enables.
- R6: Opcode 010 writes four gain bits with the same group layout as R5; 1 selects gain 2 and 0 selects gain 1.
- R7: An output's drive enable is 1 only when its own enable, the common enable and power-on are all 1.
- R8: Opcode 011 with bit 8 at 0 loads the broadcast source from bits 12:9 and the broadcast flag from bit 7; with bit 8 at 1 it is discarded. While the flag is set, every output's source index equals the broadcast source. Routing words written meanwhile are stored, and the stored routing reappears when the flag clears.
- R9: Opcode 111 sets power-on from bit 1, common enable from bit 0 and the broadcast flag from bit 9. Ones in bits 8:2 have no effect. Opcodes 100, 101 and 110 change nothing.
- R10: The serial output is 0 while the frame enable is high. Within a frame, after each falling serial-clock edge it shows the bit that the preceding rising edge pushed out of bit 15 of the 16-bit shift register. That register holds its contents between frames and resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_n_i | input | 1 | Serial frame enable, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| route_sel_o | output | NUM_OUT*4 | Effective source index per output, output o in bits 4o+3:4o |
| drive_en_o | output | NUM_OUT | Per-output drive enable |
| gain2_o | output | NUM_OUT | Per-output gain select, 1 = gain 2 |

## Verification
The in-RTL assertions cover the properties that hold on every cycle. At most one kind of register write happens per cycle. Stored routing changes only on a routing write, including while broadcast is active. The shift register and serial output hold still while the frame enable is high, and the frame-done strobe lasts a single cycle. The bench's scenarios are needed for everything else. They show the field positions of each opcode and the discarding of malformed, short and long frames. They also cover the three-way drive gating, broadcast override and restore through both command paths, and the serial output carrying the displaced bits of earlier frames.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

    localparam int WORD_W   = 16;
    localparam int CNT_W    = 5;
    localparam int FIELD_W  = 4;
    localparam int GRP_W    = 2;
    localparam int GRP_SIZE = 4;

    typedef enum logic [2:0] {
        OP_ROUTE  = 3'b000,
        OP_OUTEN  = 3'b001,
        OP_GAIN   = 3'b010,
        OP_BCAST  = 3'b011,
        OP_GLOBAL = 3'b111
    } opcode_e;

    typedef struct packed {
        logic                route_we;
        logic [FIELD_W-1:0]  route_out;
        logic [FIELD_W-1:0]  route_src;
        logic                en_we;
        logic                gain_we;
        logic [GRP_W-1:0]    grp;
        logic [GRP_SIZE-1:0] grp_bits;
        logic                bc_we;
        logic [FIELD_W-1:0]  bc_src;
        logic                bc_on;
        logic                glob_we;
        logic                pwr;
        logic                com;
        logic                glob_bc;
    } cmd_t;

endpackage

// File: rtl/xbar_serial_rx.sv
module xbar_serial_rx
    import xbar_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_n_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              done_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [SYNC_STAGES:0]   frm;
        logic [SYNC_STAGES:0]   sck;
        logic [SYNC_STAGES-1:0] sdi;
        logic [WORD_W-1:0]      sh;
        logic [CNT_W-1:0]       cnt;
        logic                   hold;
        logic                   sdo;
        logic                   done;
        logic [WORD_W-1:0]      word;
    } rx_t;

    rx_t q, d;

    logic frm_lvl, frm_prev, sck_lvl, sck_prev, sdi_lvl;
    logic frm_fall, frm_rise, sck_rise, sck_fall;

    assign frm_lvl  = q.frm[SYNC_STAGES-1];
    assign frm_prev = q.frm[SYNC_STAGES];
    assign sck_lvl  = q.sck[SYNC_STAGES-1];
    assign sck_prev = q.sck[SYNC_STAGES];
    assign sdi_lvl  = q.sdi[SYNC_STAGES-1];

    assign frm_fall = !frm_lvl && frm_prev;
    assign frm_rise = frm_lvl && !frm_prev;
    assign sck_rise = sck_lvl && !sck_prev;
    assign sck_fall = !sck_lvl && sck_prev;

    always_comb begin
        d      = q;
        d.frm  = (SYNC_STAGES+1)'({q.frm, frm_n_i});
        d.sck  = (SYNC_STAGES+1)'({q.sck, sck_i});
        d.sdi  = SYNC_STAGES'({q.sdi, sdi_i});
        d.done = 1'b0;

        if (frm_fall) begin
            d.cnt = '0;
        end

        if (!frm_lvl && sck_rise) begin
            d.hold = q.sh[WORD_W-1];
            d.sh   = {q.sh[WORD_W-2:0], sdi_lvl};
            if (q.cnt != '1) begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (frm_lvl) begin
            d.sdo = 1'b0;
        end else if (sck_fall) begin
            d.sdo = q.hold;
        end

        if (frm_rise) begin
            d.done = (q.cnt == CNT_W'(WORD_W));
            d.word = q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.frm <= '1;
        end else begin
            q <= d;
        end
    end

    assign sdo_o  = q.sdo;
    assign done_o = q.done;
    assign word_o = q.word;

    // R3
    idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_lvl |=> $stable(q.sh));

    // R10
    sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_lvl |=> !sdo_o);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/xbar_cmd_dec.sv
module xbar_cmd_dec
    import xbar_cfg_pkg::*;
(
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    output cmd_t              cmd_o
);

    opcode_e op;

    assign op = opcode_e'(word_i[15:13]);

    always_comb begin
        cmd_o           = '0;
        cmd_o.route_src = word_i[12:9];
        cmd_o.route_out = word_i[4:1];
        cmd_o.grp       = word_i[9:8];
        cmd_o.grp_bits  = {word_i[6], word_i[4], word_i[2], word_i[0]};
        cmd_o.bc_src    = word_i[12:9];
        cmd_o.bc_on     = word_i[7];
        cmd_o.pwr       = word_i[1];
        cmd_o.com       = word_i[0];
        cmd_o.glob_bc   = word_i[9];

        if (done_i) begin
            case (op)
                OP_ROUTE:  cmd_o.route_we = !word_i[8] && !word_i[0];
                OP_OUTEN:  cmd_o.en_we    = 1'b1;
                OP_GAIN:   cmd_o.gain_we  = 1'b1;
                OP_BCAST:  cmd_o.bc_we    = !word_i[8];
                OP_GLOBAL: cmd_o.glob_we  = 1'b1;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/xbar_regfile.sv
module xbar_regfile
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  cmd_t                     cmd_i,
    output logic [NUM_OUT*FIELD_W-1:0] route_sel_o,
    output logic [NUM_OUT-1:0]       drive_en_o,
    output logic [NUM_OUT-1:0]       gain2_o
);

    localparam int SEL_W = FIELD_W;

    typedef struct packed {
        logic [NUM_OUT-1:0][SEL_W-1:0] route;
        logic [NUM_OUT-1:0]            en;
        logic [NUM_OUT-1:0]            gain;
        logic                          pwr;
        logic                          com;
        logic                          bc_on;
        logic [SEL_W-1:0]              bc_src;
    } rf_t;

    rf_t q, d;

    always_comb begin
        d = q;
        for (int o = 0; o < NUM_OUT; o++) begin
            if (cmd_i.route_we && (cmd_i.route_out == SEL_W'(o))) begin
                d.route[o] = cmd_i.route_src;
            end
            if ((o / GRP_SIZE) == int'(cmd_i.grp)) begin
                if (cmd_i.en_we) begin
                    d.en[o] = cmd_i.grp_bits[o % GRP_SIZE];
                end
                if (cmd_i.gain_we) begin
                    d.gain[o] = cmd_i.grp_bits[o % GRP_SIZE];
                end
            end
        end
        if (cmd_i.bc_we) begin
            d.bc_src = cmd_i.bc_src;
            d.bc_on  = cmd_i.bc_on;
        end
        if (cmd_i.glob_we) begin
            d.pwr   = cmd_i.pwr;
            d.com   = cmd_i.com;
            d.bc_on = cmd_i.glob_bc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assign route_sel_o[o*SEL_W +: SEL_W] = q.bc_on ? q.bc_src : q.route[o];
        assign drive_en_o[o]                 = q.en[o] & q.pwr & q.com;
        assign gain2_o[o]                    = q.gain[o];
    end

    // R9
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_i.route_we, cmd_i.en_we, cmd_i.gain_we, cmd_i.bc_we, cmd_i.glob_we}));

    // R8
    route_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_i.route_we |=> $stable(q.route));

endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
    import xbar_cfg_pkg::*;
#(
    parameter int NUM_OUT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frm_n_i,
    input  logic                       sck_i,
    input  logic                       sdi_i,
    output logic                       sdo_o,
    output logic [NUM_OUT*FIELD_W-1:0] route_sel_o,
    output logic [NUM_OUT-1:0]         drive_en_o,
    output logic [NUM_OUT-1:0]         gain2_o
);

    logic              done;
    logic [WORD_W-1:0] word;
    cmd_t              cmd;

    xbar_serial_rx #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .frm_n_i (frm_n_i),
        .sck_i   (sck_i),
        .sdi_i   (sdi_i),
        .sdo_o   (sdo_o),
        .done_o  (done),
        .word_o  (word)
    );

    xbar_cmd_dec u_dec (
        .done_i (done),
        .word_i (word),
        .cmd_o  (cmd)
    );

    xbar_regfile #(
        .NUM_OUT(NUM_OUT)
    ) u_rf (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .route_sel_o (route_sel_o),
        .drive_en_o  (drive_en_o),
        .gain2_o     (gain2_o)
    );

    // R7
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.glob_we && !(cmd.pwr && cmd.com)) |=> (drive_en_o == '0));

endmodule

// File: tb/xbar_cfg_ctrl_test.sv
module xbar_cfg_ctrl_test;

    localparam int NO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frm_n = 1'b1;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic          sdo;
    logic [NO*4-1:0] route_sel;
    logic [NO-1:0] drive_en;
    logic [NO-1:0] gain2;

    int checks = 0;
    int errors = 0;
    int settle = 0;
    bit mon_on = 1'b0;

    int m_route [NO];
    bit m_en    [NO];
    bit m_gain  [NO];
    bit m_pwr, m_com, m_bcon;
    int m_bcsrc;
    bit sdo_hist [$];

    always #5 clk = ~clk;

    xbar_cfg_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_n_i     (frm_n),
        .sck_i       (sck),
        .sdi_i       (sdi),
        .sdo_o       (sdo),
        .route_sel_o (route_sel),
        .drive_en_o  (drive_en),
        .gain2_o     (gain2)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [NO*4-1:0] exp_sel();
        logic [NO*4-1:0] v;
        for (int o = 0; o < NO; o++) v[o*4 +: 4] = 4'(m_bcon ? m_bcsrc : m_route[o]);
        return v;
    endfunction

    function automatic logic [NO-1:0] exp_en();
        logic [NO-1:0] v;
        for (int o = 0; o < NO; o++) v[o] = m_en[o] && m_pwr && m_com;
        return v;
    endfunction

    function automatic logic [NO-1:0] exp_gain();
        logic [NO-1:0] v;
        for (int o = 0; o < NO; o++) v[o] = m_gain[o];
        return v;
    endfunction

    // behavioural command model, applied only to complete 16-bit frames
    function automatic void model_apply(input logic [15:0] w, input int nbits);
        int grp;
        if (nbits != 16) return;
        grp = int'(w[9:8]);
        case (w[15:13])
            3'b000: if (!w[8] && !w[0]) m_route[int'(w[4:1])] = int'(w[12:9]);
            3'b001: for (int k = 0; k < 4; k++) m_en[4*grp+k] = w[2*k];
            3'b010: for (int k = 0; k < 4; k++) m_gain[4*grp+k] = w[2*k];
            3'b011: if (!w[8]) begin m_bcsrc = int'(w[12:9]); m_bcon = w[7]; end
            3'b111: begin m_pwr = w[1]; m_com = w[0]; m_bcon = w[9]; end
            default: ;
        endcase
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            if (settle > 0) begin
                settle--;
            end else begin
                chk(route_sel == exp_sel(), "R4/R8 route_sel", route_sel, exp_sel());
                chk(drive_en == exp_en(), "R5/R7 drive_en", drive_en, exp_en());
                chk(gain2 == exp_gain(), "R6 gain2", gain2, exp_gain());
                if (frm_n) chk(sdo == 1'b0, "R10 sdo idle", sdo, 0);
            end
        end
    end

    task automatic send(input logic [15:0] w, input int nbits);
        bit b, popped;
        frm_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            b = w[15 - (i % 16)];
            sdi = b;
            repeat (10) @(negedge clk);
            sck = 1'b1;
            popped = sdo_hist.pop_front();
            sdo_hist.push_back(b);
            repeat (10) @(negedge clk);
            sck = 1'b0;
            repeat (10) @(negedge clk);
            chk(sdo == popped, "R10 sdo shifted bit", sdo, popped);
        end
        settle = 8;
        model_apply(w, nbits);
        frm_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic idle_toggle(input int n);
        for (int i = 0; i < n; i++) begin
            sdi = ~sdi;
            repeat (8) @(negedge clk);
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        sdi = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) sdo_hist.push_back(1'b0);
        for (int o = 0; o < NO; o++) begin m_route[o] = 0; m_en[o] = 0; m_gain[o] = 0; end
        m_pwr = 0; m_com = 0; m_bcon = 0; m_bcsrc = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk(route_sel == '0, "R1 route_sel reset", route_sel, 0);
        chk(drive_en == '0, "R1 drive_en reset", drive_en, 0);
        chk(gain2 == '0, "R1 gain2 reset", gain2, 0);
        chk(sdo == 1'b0, "R1 sdo reset", sdo, 0);
        mon_on = 1'b1;

        // R4 routing words
        send(16'h0000 | (16'd9 << 9) | (16'd3 << 1), 16);
        send(16'h0000 | (16'd15 << 9) | (16'd15 << 1), 16);
        send(16'h0000 | (16'd7 << 9), 16);
        chk(route_sel[3*4 +: 4] == 4'd9, "R4 out3 source", route_sel[3*4 +: 4], 9);
        chk(route_sel[15*4 +: 4] == 4'd15, "R4 out15 source", route_sel[15*4 +: 4], 15);

        // R5 enables, R7 gated off without power
        send(16'h2055, 16);
        chk(drive_en == '0, "R7 no power no drive", drive_en, 0);
        send(16'hE003, 16);
        chk(drive_en == 16'h000F, "R5 group0 enables", drive_en, 16'h000F);
        send(16'h2311, 16);
        chk(drive_en == 16'h500F, "R5 group3 partial", drive_en, 16'h500F);

        // R6 gain
        send(16'h4144, 16);
        chk(gain2 == 16'h00A0, "R6 group1 gain", gain2, 16'h00A0);

        // R4 malformed routing words discarded
        send((16'd5 << 9) | (16'd2 << 1) | 16'h0001, 16);
        send((16'd5 << 9) | (16'd2 << 1) | 16'h0100, 16);
        chk(route_sel[2*4 +: 4] == 4'd0, "R4 reserved bits discard", route_sel[2*4 +: 4], 0);

        // R9 undefined opcodes and reserved global bits
        send(16'h80FF, 16);
        send(16'hA0FF, 16);
        send(16'hC0FF, 16);
        send(16'hE1FF, 16);
        chk(drive_en == 16'h500F, "R9 reserved bits no effect", drive_en, 16'h500F);
        send(16'hE002, 16);
        chk(drive_en == '0, "R7 common enable off", drive_en, 0);
        send(16'hE003, 16);

        // R8 broadcast override and restore
        send(16'h6000 | (16'd11 << 9) | 16'h0080, 16);
        chk(route_sel == {NO{4'd11}}, "R8 broadcast all", route_sel, {NO{4'd11}});
        send((16'd2 << 9) | (16'd4 << 1), 16);
        chk(route_sel[4*4 +: 4] == 4'd11, "R8 hidden route write", route_sel[4*4 +: 4], 11);
        send(16'h6000 | (16'd11 << 9), 16);
        chk(route_sel[4*4 +: 4] == 4'd2, "R8 restored route", route_sel[4*4 +: 4], 2);
        chk(route_sel[3*4 +: 4] == 4'd9, "R8 restored out3", route_sel[3*4 +: 4], 9);
        send(16'h6000 | (16'd6 << 9) | 16'h0180, 16);
        chk(route_sel[3*4 +: 4] == 4'd9, "R8 bit8 broadcast discard", route_sel[3*4 +: 4], 9);
        send(16'hE203, 16);
        chk(route_sel[0 +: 4] == 4'd11, "R9 global broadcast flag", route_sel[0 +: 4], 11);
        send(16'hE003, 16);

        // R2 wrong frame lengths
        send((16'd12 << 9) | (16'd6 << 1), 15);
        send((16'd12 << 9) | (16'd6 << 1), 17);
        chk(route_sel[6*4 +: 4] == 4'd0, "R2 bad length discard", route_sel[6*4 +: 4], 0);
        send((16'd12 << 9) | (16'd6 << 1), 16);
        chk(route_sel[6*4 +: 4] == 4'd12, "R2 good frame applies", route_sel[6*4 +: 4], 12);

        // R3 idle clocks
        idle_toggle(6);
        chk(route_sel[6*4 +: 4] == 4'd12, "R3 idle clocks ignored", route_sel[6*4 +: 4], 12);
        send(16'h0000, 16);

        // mixed traffic
        for (int i = 0; i < 30; i++) begin
            logic [2:0] op;
            logic [15:0] w;
            case ($urandom_range(0, 5))
                0: op = 3'b000;
                1: op = 3'b001;
                2: op = 3'b010;
                3: op = 3'b011;
                4: op = 3'b111;
                default: op = 3'b101;
            endcase
            w = {op, 13'($urandom)};
            send(w, 16);
        end

        mon_on = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule